// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block is the event status register of an 8-bit timer/counter. It watches the counter value, the two compare values, the capture input and the overflow sources. Each of four event flags is latched by its own rule: input capture, compare match A, compare match B and overflow. A latched flag drives an interrupt request when its enable is high. A flag is cleared in one of two ways. The interrupt controller can send a one-cycle acknowledge pulse for that flag, or software can write a one to the flag's bit.

The same register port also reaches a small control register. That register holds a synchronization-mode bit and a prescaler reset bit. While synchronization mode is on, the prescaler reset keeps the value last written to it. While it is off, the reset bit drops one clock after it is written high. The counter, the waveform generator and the prescaler are not part of this block. They appear only as input signals.

Top module: `tmr_flag_reg`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all four flags, the sync bit and the prescaler reset bit are 0, both register reads return 0x00, and irq is 0.
- R2: With reg_sel=0, rd_data bit 5 is the capture flag, bit 2 is compare B, bit 1 is compare A and bit 0 is overflow. Bits 7:6 and 4:3 always read 0, and a write of ones to them changes nothing.
- R3: If cnt_val equals a compare value at a clock edge with tick=1, that channel's flag becomes 1 at the next edge with tick=1, and not at the edge where the equality is seen.
- R4: A force strobe (force_a or force_b) high at the edge where the match is seen stops that match from setting the channel's flag.
- R5: When wgm is 8, 10, 12 or 14, the capture flag sets on top_hit at a tick and capt_evt is ignored. For every other wgm, it sets on capt_evt at a tick and top_hit is ignored.
- R6: When wgm is 0, 4 or 12, the overflow flag sets on cnt_ovf at a tick. For every other wgm, it sets on ovf_alt at a tick.
- R7: ack bit i (0 = overflow, 1 = compare A, 2 = compare B, 3 = capture) clears the matching flag at the next edge.
- R8: A write with reg_sel=0 clears each flag whose bit position in wr_data is 1. Flags whose bit is 0 keep their value.
- R9: If a set event and a clear (ack or write-one) for the same flag fall in the same cycle, the flag ends at 1.
- R10: irq[i] equals flag i AND irq_en[i], using the index order given in R7.
- R11: No flag becomes 1 at an edge where tick=0.
- R12: With reg_sel=1, rd_data bit 7 is the sync bit and bit 0 is the prescaler reset, and a write loads both. With sync=1, the reset bit keeps its value. With sync=0, a reset bit of 1 returns to 0 one clock after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Timer clock enable; flag set logic advances only when high |
| wgm | input | 4 | Waveform mode code |
| cnt_val | input | 8 | Current counter value |
| cmp_a | input | 8 | Compare value, channel A |
| cmp_b | input | 8 | Compare value, channel B |
| force_a | input | 1 | Forced-compare strobe, channel A |
| force_b | input | 1 | Forced-compare strobe, channel B |
| capt_evt | input | 1 | Capture event from the capture pin logic |
| top_hit | input | 1 | Counter has reached TOP |
| cnt_ovf | input | 1 | Counter overflow (used in plain modes) |
| ovf_alt | input | 1 | Mode-dependent overflow set source |
| ack | input | 4 | Per-flag interrupt acknowledge pulses |
| irq_en | input | 4 | Per-flag interrupt enables |
| reg_sel | input | 1 | 0 = flag register, 1 = control register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for the selected register |
| irq | output | 4 | Per-flag interrupt requests |
| psr_rst | output | 1 | Prescaler reset to the prescaler |

## Verification
The bench targets the cycle at which a compare flag rises. A design that skips the delay stage sets the flag one tick early. A design that registers the force strobe late lets a forced match through. It also checks that a clear arriving with a set leaves the flag at 1, where a clear-priority design would lose the event. It checks that each of the mode-dependent set sources follows wgm, where a swapped decode would pick the wrong input. Finally, it checks that the prescaler reset stays high under sync mode but drops after one clock without it. A design with no hold would drop the reset, and one with no self-clear would leave the prescaler in reset.

// File: rtl/tfr_pkg.sv
// Package: shared constants and mode decode for the timer flag register.
// Assumes an 8-bit register port and the four-flag index order below.
package tfr_pkg;
    localparam int REG_W    = 8;
    localparam int NFLAG    = 4;
    localparam int IDX_OVF  = 0;
    localparam int IDX_CMPA = 1;
    localparam int IDX_CMPB = 2;
    localparam int IDX_CAPT = 3;
    localparam int CTL_SYNC_POS = 7;
    localparam int CTL_PRST_POS = 0;
    localparam logic [REG_W-1:0] RSVD_MASK = 8'b1101_1000;

    // Bit position of a flag inside the status register.
    function automatic int flag_pos(input int idx);
        case (idx)
            IDX_OVF:  return 0;
            IDX_CMPA: return 1;
            IDX_CMPB: return 2;
            default:  return 5;
        endcase
    endfunction

    // Modes in which the plain counter overflow sets the overflow flag.
    function automatic logic ovf_is_plain(input logic [3:0] m);
        return (m == 4'd0) || (m == 4'd4) || (m == 4'd12);
    endfunction

    // Modes in which the capture register serves as TOP.
    function automatic logic capt_is_top(input logic [3:0] m);
        return (m == 4'd8) || (m == 4'd10) || (m == 4'd12) || (m == 4'd14);
    endfunction
endpackage

// File: rtl/tfr_flag_bit.sv
// Module: one sticky event flag.
// Sets on set_i, clears on clr_i; set takes priority so no event is lost.
// Assumes set_i is already qualified by the timer clock enable.
module tfr_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Flag storage with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !q) |=> !q);
endmodule

// File: rtl/tfr_cmp_chan.sv
// Module: compare-match detector for one output-compare channel.
// Registers the equality on a tick so the flag set comes one tick later.
// A force strobe at the matching tick suppresses the pending set.
module tfr_cmp_chan #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             force_i,
    output logic             hit
);
    logic pend;
    logic eq;

    // Equality between counter and compare value.
    always_comb eq = (cnt == cmp);

    // Pending match, captured on each tick, blocked by a force strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (tick) pend <= eq && !force_i;
    end

    // Set pulse one tick after the match was seen.
    always_comb hit = tick && pend;

    a_r3_match_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eq && !force_i) |=> pend);
    a_r4_force_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && force_i) |=> !pend);
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pend));
endmodule

// File: rtl/tfr_sync_ctl.sv
// Module: synchronization-mode bit and prescaler reset bit.
// With sync on, the reset bit keeps its written value; otherwise it
// drops one clock after being set. A write loads both bits together.
module tfr_sync_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wd_sync,
    input  logic wd_prst,
    output logic sync_q,
    output logic prst_q
);
    // Control register update with self-clear of the reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            prst_q <= 1'b0;
        end else if (wr) begin
            sync_q <= wd_sync;
            prst_q <= wd_prst;
        end else if (!sync_q) begin
            prst_q <= 1'b0;
        end
    end

    a_r12_hold_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q && prst_q && !wr) |=> prst_q);
    a_r12_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_q && !wr) |=> !prst_q);
endmodule

// File: rtl/tmr_flag_reg.sv
// Module: timer interrupt flag register, top level.
// Builds the set sources for four flags from the event inputs and the mode,
// the clear sources from acknowledges and write-one-to-clear, and muxes the
// flag and control registers onto the read port. Assumes single-cycle acks.
module tmr_flag_reg
    import tfr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [3:0]       wgm,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             force_a,
    input  logic             force_b,
    input  logic             capt_evt,
    input  logic             top_hit,
    input  logic             cnt_ovf,
    input  logic             ovf_alt,
    input  logic [3:0]       ack,
    input  logic [3:0]       irq_en,
    input  logic             reg_sel,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic [3:0]       irq,
    output logic             psr_rst
);
    localparam int NCMP = 2;

    logic [NCMP-1:0][CNT_W-1:0] cmp_vec;
    logic [NCMP-1:0]            frc_vec;
    logic [NCMP-1:0]            cmp_hit;
    logic [NFLAG-1:0]           set_v;
    logic [NFLAG-1:0]           clr_v;
    logic [NFLAG-1:0]           flags;
    logic                       wr_flag;
    logic                       wr_ctl;
    logic                       sync_q;
    logic                       rsvd_wr;

    // Group per-channel compare inputs for the generate loop.
    always_comb begin
        cmp_vec[0] = cmp_a;
        cmp_vec[1] = cmp_b;
        frc_vec    = {force_b, force_a};
    end

    genvar c;
    generate
        for (c = 0; c < NCMP; c++) begin : g_cmp
            tfr_cmp_chan #(.CNT_W(CNT_W)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .cnt     (cnt_val),
                .cmp     (cmp_vec[c]),
                .force_i (frc_vec[c]),
                .hit     (cmp_hit[c])
            );
        end
    endgenerate

    // Set sources per flag, gated by the timer clock enable.
    always_comb begin
        set_v[IDX_OVF]  = tick && (ovf_is_plain(wgm) ? cnt_ovf : ovf_alt);
        set_v[IDX_CMPA] = cmp_hit[0];
        set_v[IDX_CMPB] = cmp_hit[1];
        set_v[IDX_CAPT] = tick && (capt_is_top(wgm) ? top_hit : capt_evt);
    end

    // Write strobes per register and reserved-bit write detect.
    always_comb begin
        wr_flag = wr_en && !reg_sel;
        wr_ctl  = wr_en && reg_sel;
        rsvd_wr = wr_flag && |(wr_data & RSVD_MASK);
    end

    genvar f;
    generate
        for (f = 0; f < NFLAG; f++) begin : g_flag
            // Clear source: acknowledge or write-one at the flag's position.
            always_comb clr_v[f] = ack[f] || (wr_flag && wr_data[flag_pos(f)]);

            tfr_flag_bit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_v[f]),
                .clr_i (clr_v[f]),
                .q     (flags[f])
            );
        end
    endgenerate

    tfr_sync_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_ctl),
        .wd_sync (wr_data[CTL_SYNC_POS]),
        .wd_prst (wr_data[CTL_PRST_POS]),
        .sync_q  (sync_q),
        .prst_q  (psr_rst)
    );

    // Read mux: flag register with reserved zeros, or control register.
    always_comb begin
        rd_data = '0;
        if (!reg_sel) begin
            for (int i = 0; i < NFLAG; i++) rd_data[flag_pos(i)] = flags[i];
        end else begin
            rd_data[CTL_SYNC_POS] = sync_q;
            rd_data[CTL_PRST_POS] = psr_rst;
        end
    end

    // Interrupt requests: flag qualified by its enable.
    always_comb irq = flags & irq_en;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsvd_wr || !reg_sel) |=> (reg_sel || ((rd_data & RSVD_MASK) == '0)));
    a_r10_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~irq_en) == '0));
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (irq == '0 && !psr_rst));
endmodule

// File: tb/sim_tmr_flag_reg.sv
// Bench: directed corners plus seeded random traffic, checked each cycle
// against a behavioural model built from the requirements.
module sim_tmr_flag_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [3:0] wgm = '0;
    logic [7:0] cnt_val = '0, cmp_a = 8'hff, cmp_b = 8'hff;
    logic force_a = 0, force_b = 0, capt_evt = 0, top_hit = 0, cnt_ovf = 0, ovf_alt = 0;
    logic [3:0] ack = '0, irq_en = '0;
    logic reg_sel = 0, wr_en = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [3:0] irq;
    logic psr_rst;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Model state.
    logic [3:0] m_f = '0;
    logic m_pa = 0, m_pb = 0, m_sync = 0, m_prst = 0;

    always #2 clk = ~clk;

    tmr_flag_reg u0 (.*);

    function automatic logic plain_ovf(input logic [3:0] m);
        return m == 0 || m == 4 || m == 12;
    endfunction
    function automatic logic icr_top(input logic [3:0] m);
        return m == 8 || m == 10 || m == 12 || m == 14;
    endfunction
    function automatic logic [7:0] exp_rd(input logic sel);
        return sel ? {m_sync, 6'b0, m_prst} : {2'b0, m_f[3], 2'b0, m_f[2], m_f[1], m_f[0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: predict from current inputs, advance, compare at the ports.
    task automatic step(input string tag);
        logic [3:0] s, cl, nf;
        s[0] = tick && (plain_ovf(wgm) ? cnt_ovf : ovf_alt);
        s[1] = tick && m_pa;
        s[2] = tick && m_pb;
        s[3] = tick && (icr_top(wgm) ? top_hit : capt_evt);
        cl = ack | ((wr_en && !reg_sel) ? {wr_data[5], wr_data[2], wr_data[1], wr_data[0]} : 4'b0);
        for (int i = 0; i < 4; i++) nf[i] = s[i] ? 1'b1 : (cl[i] ? 1'b0 : m_f[i]);
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_f = '0; m_pa = 0; m_pb = 0; m_sync = 0; m_prst = 0;
        end else begin
            m_f = nf;
            if (tick) begin
                m_pa = (cnt_val == cmp_a) && !force_a;
                m_pb = (cnt_val == cmp_b) && !force_b;
            end
            if (wr_en && reg_sel) begin
                m_sync = wr_data[7]; m_prst = wr_data[0];
            end else if (!m_sync) m_prst = 0;
        end
        chk({tag, " rd"}, rd_data, exp_rd(reg_sel));
        chk({tag, " irq"}, irq, m_f & irq_en);
        chk({tag, " psr"}, psr_rst, m_prst);
    endtask

    task automatic idle();
        tick = 0; wr_en = 0; ack = '0; force_a = 0; force_b = 0;
        capt_evt = 0; top_hit = 0; cnt_ovf = 0; ovf_alt = 0;
    endtask

    initial begin
        #80000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state.
        step("R1 reset");
        step("R1 reset");
        rst_n = 1;
        irq_en = 4'hf;
        chk("R1 flags zero", rd_data, 8'h00);
        reg_sel = 1; #1;
        chk("R1 ctrl zero", rd_data, 8'h00);
        reg_sel = 0;

        // R2: writing reserved ones leaves reads zero.
        wr_en = 1; wr_data = 8'hd8; step("R2 reserved write");
        idle(); step("R2 reserved after");
        chk("R2 reserved bits", rd_data & 8'hd8, 8'h00);

        // R3: compare A flag rises one tick after the match.
        cnt_val = 8'h10; cmp_a = 8'h10; tick = 1; step("R3 match tick");
        chk("R3 not yet set", rd_data[1], 1'b0);
        cnt_val = 8'h11; step("R3 next tick");
        chk("R3 set next tick", rd_data[1], 1'b1);
        idle(); ack = 4'b0010; step("R7 ack cmpA");
        chk("R7 cleared by ack", rd_data[1], 1'b0);

        // R4: force strobe at match blocks the set.
        ack = '0; cnt_val = 8'h20; cmp_b = 8'h20; force_b = 1; tick = 1; step("R4 forced");
        force_b = 0; cnt_val = 8'h21; step("R4 after");
        chk("R4 compare B stays clear", rd_data[2], 1'b0);

        // R5: capture source selection.
        idle(); wgm = 4'd12; capt_evt = 1; tick = 1; step("R5 evt ignored");
        chk("R5 capt_evt ignored in top mode", rd_data[5], 1'b0);
        capt_evt = 0; top_hit = 1; step("R5 top hit");
        chk("R5 top_hit sets", rd_data[5], 1'b1);
        idle(); wr_en = 1; wr_data = 8'h20; step("R8 clear capt");
        chk("R8 write one clears", rd_data[5], 1'b0);

        // R6: overflow source selection.
        idle(); wgm = 4'd5; cnt_ovf = 1; tick = 1; step("R6 plain ignored");
        chk("R6 cnt_ovf ignored", rd_data[0], 1'b0);
        cnt_ovf = 0; ovf_alt = 1; step("R6 alt");
        chk("R6 ovf_alt sets", rd_data[0], 1'b1);

        // R8: write zero keeps; R9: set beats clear.
        idle(); wr_en = 1; wr_data = 8'h00; step("R8 write zero");
        chk("R8 zero keeps", rd_data[0], 1'b1);
        wr_en = 1; wr_data = 8'h01; ack = 4'b0001; ovf_alt = 1; tick = 1; step("R9 collide");
        chk("R9 set wins", rd_data[0], 1'b1);

        // R11: no set without tick.
        idle(); wgm = 0; cnt_ovf = 1; capt_evt = 1; ack = 4'b0001; step("R11 no tick");
        ack = '0; step("R11 no tick 2");
        chk("R11 flags idle", rd_data & 8'h21, 8'h00);

        // R10: irq masked by enable.
        idle(); cnt_ovf = 1; tick = 1; irq_en = 4'b1110; step("R10 masked");
        chk("R10 irq masked", irq[0], 1'b0);
        irq_en = 4'hf; #1; chk("R10 irq enabled", irq[0], 1'b1);

        // R12: control register hold and self-clear.
        idle(); reg_sel = 1; wr_en = 1; wr_data = 8'h81; step("R12 sync write");
        wr_en = 0; step("R12 hold"); step("R12 hold 2");
        chk("R12 held under sync", psr_rst, 1'b1);
        wr_en = 1; wr_data = 8'h01; step("R12 plain write");
        chk("R12 pulse visible", psr_rst, 1'b1);
        wr_en = 0; step("R12 self clear");
        chk("R12 self cleared", psr_rst, 1'b0);

        // Random traffic checked against the model (R3..R12).
        for (int k = 0; k < 3000; k++) begin
            tick = ($urandom % 4) != 0;
            wgm = 4'($urandom);
            cnt_val = 8'($urandom % 8);
            cmp_a = 8'($urandom % 8);
            cmp_b = 8'($urandom % 8);
            force_a = ($urandom % 8) == 0;
            force_b = ($urandom % 8) == 0;
            capt_evt = ($urandom % 5) == 0;
            top_hit = ($urandom % 5) == 0;
            cnt_ovf = ($urandom % 5) == 0;
            ovf_alt = ($urandom % 5) == 0;
            ack = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0;
            irq_en = 4'($urandom);
            reg_sel = $urandom % 2;
            wr_en = ($urandom % 6) == 0;
            wr_data = 8'($urandom);
            step("R9 random model");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule